// File: doc/BRIEF.md
# Hold-High Synchronization and Power-Down Controller

This block is the control logic of a converter that watches its serial clock line and its two channel-select lines and turns what it sees into requests for the modulator. The serial clock idles low during normal operation. If a host keeps it high, the block counts conversion periods, which arrive as single-cycle ticks from the conversion sequencer. After a first threshold it holds the modulator in reset and gives a short active-low marker. After a second, longer threshold it also requests power-down. Both states end when the serial clock goes low again, and a one-cycle restart request then starts conversion afresh, so the next ready indication carries valid data.

A change of the two select bits also issues a restart, and the newly selected channel appears at the output, so the first result after the change comes from the new input. All asynchronous inputs pass through a two-flop synchronizer before any detection. The hold counter is cleared whenever the synchronized serial clock is low, so ordinary data reads, which keep the line high for far less than a conversion period, never reach a threshold.

Top module: `hold_sync_ctrl`

## Requirements
- R1: After reset, mod_reset = 0, power_down = 0, restart = 0, marker_n = 1 and chan_sel = 2'b00.
- R2: With the synchronized serial clock high, mod_reset rises at the clock edge that samples the SYNC_PERIODS-th conv_tick (4 by default) and not before.
- R3: On entry to reset, marker_n is low for exactly MARK_CLKS system clocks (3 by default) starting at that same edge, then returns high while reset holds.
- R4: power_down rises at the edge that samples the (SYNC_PERIODS + PDN_PERIODS)-th tick (20 by default), mod_reset stays high, and further ticks change nothing.
- R5: Any cycle with the synchronized serial clock low clears the hold count, so ticks before a low period do not add to ticks after it.
- R6: When the serial clock falls while held, mod_reset and power_down clear and restart is high for one cycle, on the third rising edge after the input change.
- R7: chan_sel follows the select inputs with 00 = channel 1, 01 = channel 2, 10 = channel 3, 11 = channel 4; a change of the select value gives a one-cycle restart at the same edge where chan_sel changes.
- R8: Inputs are synchronized by two flops: a select change reaches chan_sel on the third rising edge after it is applied, and rewriting the same value gives no restart.
- R9: Ticks with the serial clock low, and a high serial clock without ticks, never assert mod_reset, power_down or restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_in | input | 1 | Serial clock line, asynchronous, idles low |
| chsel_in | input | 2 | Channel-select bits, asynchronous |
| conv_tick | input | 1 | One-cycle pulse per conversion period |
| mod_reset | output | 1 | Hold the modulator in reset |
| power_down | output | 1 | Power-down request |
| restart | output | 1 | One-cycle conversion restart request |
| marker_n | output | 1 | Active-low marker given on entry to reset |
| chan_sel | output | 2 | Selected channel code |

## Verification
The bench builds the block with its default parameters: 4 periods to reset, 16 further periods to power-down and a 3-clock marker. These keep both thresholds and saturation of the counter within a few dozen ticks, so the bench can walk every tick up to and past power-down. It can also break a hold just before the first threshold and confirm that the count restarts, and it can check the marker clock by clock.

// File: rtl/hold_sync_pkg.sv
package hold_sync_pkg;

  typedef enum logic [1:0] {
    CHAN_1 = 2'b00,
    CHAN_2 = 2'b01,
    CHAN_3 = 2'b10,
    CHAN_4 = 2'b11
  } chan_e;

  // Next value of the hold counter: cleared when the line is low,
  // advanced per tick while high, saturating at cap.
  function automatic int unsigned hold_next(input int unsigned cur,
                                            input logic line_high,
                                            input logic tick,
                                            input int unsigned cap);
    if (!line_high) return 0;
    if (tick && (cur < cap)) return cur + 1;
    return cur;
  endfunction

endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage[0] <= '0;
    else        stage[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage[s] <= '0;
      else        stage[s] <= stage[s-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/hold_counter.sv
module hold_counter
  import hold_sync_pkg::*;
#(
  parameter int SYNC_PERIODS = 4,
  parameter int PDN_PERIODS  = 16,
  localparam int CAP   = SYNC_PERIODS + PDN_PERIODS,
  localparam int CNT_W = $clog2(CAP + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_high,
  input  logic tick,
  output logic entry_evt,
  output logic release_evt,
  output logic in_sync,
  output logic in_pdn
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= CNT_W'(hold_next(int'(cnt), line_high, tick, CAP));
  end

  assign in_sync     = (int'(cnt) >= SYNC_PERIODS);
  assign in_pdn      = (int'(cnt) >= CAP);
  assign entry_evt   = line_high && tick && (int'(cnt) == SYNC_PERIODS - 1);
  assign release_evt = !line_high && in_sync;
endmodule

// File: rtl/marker_gen.sv
module marker_gen #(
  parameter int MARK_CLKS = 3,
  localparam int MW = $clog2(MARK_CLKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic clear,
  output logic marker_n
);
  logic [MW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          left <= '0;
    else if (clear)      left <= '0;
    else if (load)       left <= MW'(MARK_CLKS);
    else if (left != '0) left <= left - 1'b1;
  end

  assign marker_n = (left == '0);
endmodule

// File: rtl/chan_tracker.sv
module chan_tracker
  import hold_sync_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel_s,
  output logic [1:0] chan,
  output logic       changed
);
  chan_e cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur <= CHAN_1;
    else        cur <= chan_e'(sel_s);
  end

  assign chan    = cur;
  assign changed = (sel_s != cur);
endmodule

// File: rtl/hold_sync_ctrl.sv
module hold_sync_ctrl #(
  parameter int SYNC_PERIODS = 4,
  parameter int PDN_PERIODS  = 16,
  parameter int MARK_CLKS    = 3,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk_in,
  input  logic [1:0] chsel_in,
  input  logic       conv_tick,
  output logic       mod_reset,
  output logic       power_down,
  output logic       restart,
  output logic       marker_n,
  output logic [1:0] chan_sel
);
  logic [2:0] raw_in, sync_out;
  logic       sclk_s;
  logic [1:0] chsel_s;
  logic       entry_evt, release_evt, chan_chg;

  assign raw_in = {sclk_in, chsel_in};

  edge_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(sync_out)
  );
  assign sclk_s  = sync_out[2];
  assign chsel_s = sync_out[1:0];

  hold_counter #(.SYNC_PERIODS(SYNC_PERIODS), .PDN_PERIODS(PDN_PERIODS)) u_hold (
    .clk(clk), .rst_n(rst_n), .line_high(sclk_s), .tick(conv_tick),
    .entry_evt(entry_evt), .release_evt(release_evt),
    .in_sync(mod_reset), .in_pdn(power_down)
  );

  marker_gen #(.MARK_CLKS(MARK_CLKS)) u_mark (
    .clk(clk), .rst_n(rst_n), .load(entry_evt), .clear(!sclk_s),
    .marker_n(marker_n)
  );

  chan_tracker u_chan (
    .clk(clk), .rst_n(rst_n), .sel_s(chsel_s), .chan(chan_sel), .changed(chan_chg)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) restart <= 1'b0;
    else        restart <= chan_chg | release_evt;
  end
endmodule

// File: rtl/hold_sync_checker.sv
module hold_sync_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       sclk_s,
  input logic       mod_reset,
  input logic       power_down,
  input logic       restart,
  input logic       marker_n,
  input logic [1:0] chan_sel
);
  // R4: power-down only ever occurs inside the reset state
  a_r4_pdn_inside_reset: assert property (@(posedge clk) disable iff (!rst_n)
    power_down |-> mod_reset);

  // R3: marker only appears while the modulator is held
  a_r3_marker_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !marker_n |-> mod_reset);

  // R3: marker starts together with entry and lasts more than one clock
  a_r3_marker_at_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(marker_n) |-> $rose(mod_reset));
  a_r3_marker_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(marker_n) |=> !marker_n);

  // R6: a low line while held releases at the next edge with a restart
  a_r6_release_next: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_reset && !sclk_s) |=> (!mod_reset && !power_down && restart));
  a_r6_fall_restart: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mod_reset) |-> restart);

  // R7: every channel change is accompanied by a restart
  a_r7_chan_restart: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(chan_sel) |-> restart);
endmodule

bind hold_sync_ctrl hold_sync_checker u_chk (
  .clk(clk), .rst_n(rst_n), .sclk_s(sclk_s), .mod_reset(mod_reset),
  .power_down(power_down), .restart(restart), .marker_n(marker_n),
  .chan_sel(chan_sel)
);

// File: tb/hold_sync_ctrl_bench.sv
`timescale 1ns/1ps
module hold_sync_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk_in = 1'b0;
  logic [1:0] chsel_in = 2'b00;
  logic       conv_tick = 1'b0;
  logic       mod_reset, power_down, restart, marker_n;
  logic [1:0] chan_sel;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  hold_sync_ctrl u_hold_sync_ctrl (
    .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .chsel_in(chsel_in),
    .conv_tick(conv_tick), .mod_reset(mod_reset), .power_down(power_down),
    .restart(restart), .marker_n(marker_n), .chan_sel(chan_sel)
  );

  // {select value, expected restart after three edges}; 00=ch1 .. 11=ch4
  localparam logic [2:0] VEC [7] = '{
    3'b01_1, 3'b10_1, 3'b11_1, 3'b11_0, 3'b00_1, 3'b00_0, 3'b10_1
  };

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      conv_tick = 1'b1;
      step();
      conv_tick = 1'b0;
    end
  endtask

  initial begin
    #500000;
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    step(2);
    rst_n = 1'b1;
    step();
    // R1 reset state
    check("R1 mod_reset", mod_reset, 0);
    check("R1 power_down", power_down, 0);
    check("R1 restart", restart, 0);
    check("R1 marker_n", marker_n, 1);
    check("R1 chan_sel", chan_sel, 0);

    // R7 R8 table walk of channel selections
    foreach (VEC[k]) begin
      chsel_in = VEC[k][2:1];
      step(2);
      check("R8 chan_sel not yet", chan_sel, (k == 0) ? 2'b00 : VEC[k-1][2:1]);
      step();
      check("R7 chan_sel", chan_sel, VEC[k][2:1]);
      check("R7 restart pulse", restart, VEC[k][0]);
      step();
      check("R7 restart one cycle", restart, 0);
    end

    // R9 ticks with line low do nothing
    tick(30);
    check("R9 no reset low line", mod_reset, 0);
    check("R9 no restart", restart, 0);
    // R9 line high without ticks does nothing
    sclk_in = 1'b1;
    step(40);
    check("R9 no reset without ticks", mod_reset, 0);
    check("R9 marker idle", marker_n, 1);

    // R5 break the hold before the threshold
    tick(3);
    check("R2 not yet at 3", mod_reset, 0);
    sclk_in = 1'b0;
    step(3);
    check("R5 no restart on short hold", restart, 0);
    sclk_in = 1'b1;
    step(2);
    tick(3);
    check("R5 count restarted", mod_reset, 0);
    tick();
    check("R2 reset at 4th tick", mod_reset, 1);
    check("R3 marker low clk1", marker_n, 0);
    step();
    check("R3 marker low clk2", marker_n, 0);
    step();
    check("R3 marker low clk3", marker_n, 0);
    step();
    check("R3 marker high after 3", marker_n, 1);
    check("R2 reset holds", mod_reset, 1);

    // R4 power-down after 16 further ticks
    tick(15);
    check("R4 no pdn at 19", power_down, 0);
    tick();
    check("R4 pdn at 20", power_down, 1);
    check("R4 reset kept", mod_reset, 1);
    tick(10);
    check("R4 saturated pdn", power_down, 1);
    check("R4 marker stays high", marker_n, 1);

    // R6 release from power-down
    sclk_in = 1'b0;
    step(2);
    check("R6 still held before sync", power_down, 1);
    step();
    check("R6 pdn cleared", power_down, 0);
    check("R6 reset cleared", mod_reset, 0);
    check("R6 restart", restart, 1);
    step();
    check("R6 restart one cycle", restart, 0);

    // R6 release from reset only, during marker
    sclk_in = 1'b1;
    step(2);
    tick(4);
    check("R2 reset again", mod_reset, 1);
    sclk_in = 1'b0;
    step(3);
    check("R6 reset release", mod_reset, 0);
    check("R6 marker released", marker_n, 1);
    check("R6 restart after sync", restart, 1);
    step();
    check("R6 restart ends", restart, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule